// File: doc/BRIEF.md
# Machine-Check Error Bank Logger

This block keeps a small set of error-reporting banks for a processor core. Each bank holds a status word, an address word and a miscellaneous word. Each bank's control word is a configuration input. A global capability word, a global control word and an enable for machine-check delivery are also inputs. The block keeps one global status word of its own.

Error sources inject a record with a single-cycle request strobe. The record carries a bank index, a status word, a global status word, an address, a misc word and an unconditional flag. The block screens the request and then applies the logging rules. Uncorrected errors may be suppressed, may escalate to a reset request, or may be logged with an interrupt. Corrected errors are logged quietly, or only flag an overflow when they meet a pending uncorrected entry.

A combinational observation port returns the contents of one bank and the global status, so the surrounding logic can inspect what was logged.

Top module: `mc_bank_logger`

## Requirements
- R1: After reset every bank's status, address and misc words read zero, the global status reads zero, and irq_o, reset_req_o and reject_o are low.
- R2: A request is rejected with reject_o high for one cycle, with no state change, and with reject_code_o as follows, checked in this order: 1 if cap_i is zero; 2 if req_bank_i is at least cap_i[7:0] or at least NUM_BANKS; 3 if status bit 63 (valid) is clear.
- R3: When global status bit 2 (check in progress) is set, a request whose status bit 55 (action required) is clear and whose req_uncond_i is low is ignored: no output pulse and no bank change.
- R4: An uncorrected error (status bit 61) is dropped when cap_i bit 8 is set and gctl_i is not all ones. When cap_i bit 8 is clear, gctl_i has no effect.
- R5: An uncorrected error is dropped when the selected bank's control word is not all ones. Corrected errors are not affected by the control word.
- R6: An uncorrected error that is not dropped, and that arrives while global status bit 2 is set or mce_en_i is low, pulses reset_req_o for one cycle and changes no bank or global state.
- R7: Otherwise an uncorrected error writes the bank's status, address and misc words, loads the global status from req_gstatus_i, and pulses irq_o for one cycle.
- R8: When an uncorrected error is logged over a bank whose status already has bit 63 set, the stored status also gets bit 62 (overflow) set.
- R9: A corrected error whose target bank's status is not valid, or valid but not uncorrected, overwrites status, address and misc. Bit 62 is set if the old status was valid. No interrupt is raised and the global status is unchanged.
- R10: A corrected error that meets a valid uncorrected entry only sets bit 62 of the existing status. The address and misc words stay unchanged.
- R11: Every response pulse appears in the cycle after the request edge and lasts one cycle. Back-to-back requests are handled in consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cap_i | input | 64 | Global capability: [7:0] bank count, bit 8 global control present |
| gctl_i | input | 64 | Global control word |
| mce_en_i | input | 1 | Machine-check delivery enabled |
| bank_ctl_i | input | NUM_BANKS*64 | Per-bank control words, bank b at [b*64 +: 64] |
| req_i | input | 1 | Injection request strobe |
| req_bank_i | input | 8 | Target bank index |
| req_status_i | input | 64 | Error status word |
| req_gstatus_i | input | 64 | Global status to load on an interrupting log |
| req_addr_i | input | 64 | Error address word |
| req_misc_i | input | 64 | Error misc word |
| req_uncond_i | input | 1 | Log even while a check is in progress |
| irq_o | output | 1 | Machine-check interrupt pulse |
| reset_req_o | output | 1 | Reset request pulse |
| reject_o | output | 1 | Request rejected pulse |
| reject_code_o | output | 2 | Reject reason, valid with reject_o |
| obs_bank_i | input | IDX_W | Bank selected for observation |
| obs_status_o | output | 64 | Observed bank status |
| obs_addr_o | output | 64 | Observed bank address |
| obs_misc_o | output | 64 | Observed bank misc |
| gstatus_o | output | 64 | Global status word |

## Verification
The ignore rule and the escalation rule both key on the check-in-progress bit, so one request can qualify for either. The bench first logs an uncorrected error whose global status sets that bit. It then sends a non-action-required corrected error, which must vanish, and the same error with the unconditional flag, which must log. After that, an action-required uncorrected error must give a reset request and not an interrupt. A scoreboard reference model predicts each pulse and the bank contents. The monitor compares them one edge after each request, and it requires all pulses low in every idle cycle.

// File: rtl/mcb_pkg.sv
package mcb_pkg;
  localparam int WORD_W    = 64;
  localparam int ST_VAL    = 63;
  localparam int ST_OVER   = 62;
  localparam int ST_UC     = 61;
  localparam int ST_AR     = 55;
  localparam int GS_MCIP   = 2;
  localparam int CAP_CTLP  = 8;
  localparam int CAP_CNT_W = 8;

  typedef logic [WORD_W-1:0] word_t;

  typedef enum logic [1:0] {
    REJ_NONE   = 2'd0,
    REJ_NOCAP  = 2'd1,
    REJ_BANK   = 2'd2,
    REJ_STATUS = 2'd3
  } rej_e;

  typedef enum logic [2:0] {
    ACT_SKIP,
    ACT_ESCALATE,
    ACT_LOG_UC,
    ACT_LOG_CE,
    ACT_MARK_OVER
  } act_e;
endpackage

// File: rtl/mcb_screen.sv
module mcb_screen import mcb_pkg::*; #(
  parameter int NUM_BANKS = 4
) (
  input  word_t                cap_i,
  input  logic [CAP_CNT_W-1:0] bank_i,
  input  word_t                status_i,
  output rej_e                 code_o
);
  localparam logic [CAP_CNT_W:0] PHYS_CNT = (CAP_CNT_W+1)'(NUM_BANKS);

  logic bank_bad;
  assign bank_bad = (bank_i >= cap_i[CAP_CNT_W-1:0]) || ({1'b0, bank_i} >= PHYS_CNT);

  always_comb begin
    if (cap_i == '0)             code_o = REJ_NOCAP;
    else if (bank_bad)           code_o = REJ_BANK;
    else if (!status_i[ST_VAL])  code_o = REJ_STATUS;
    else                         code_o = REJ_NONE;
  end
endmodule

// File: rtl/mcb_decide.sv
module mcb_decide import mcb_pkg::*; (
  input  word_t status_i,
  input  logic  uncond_i,
  input  word_t gstat_i,
  input  word_t cap_i,
  input  word_t gctl_i,
  input  word_t bank_ctl_i,
  input  logic  mce_en_i,
  input  word_t old_status_i,
  output act_e  act_o
);
  logic mcip, uc, ar;
  assign mcip = gstat_i[GS_MCIP];
  assign uc   = status_i[ST_UC];
  assign ar   = status_i[ST_AR];

  always_comb begin
    if (!uncond_i && !ar && mcip) begin
      act_o = ACT_SKIP;
    end else if (uc) begin
      if (cap_i[CAP_CTLP] && (gctl_i != '1))  act_o = ACT_SKIP;
      else if (bank_ctl_i != '1)              act_o = ACT_SKIP;
      else if (mcip || !mce_en_i)             act_o = ACT_ESCALATE;
      else                                    act_o = ACT_LOG_UC;
    end else if (!old_status_i[ST_VAL] || !old_status_i[ST_UC]) begin
      act_o = ACT_LOG_CE;
    end else begin
      act_o = ACT_MARK_OVER;
    end
  end
endmodule

// File: rtl/mcb_bank.sv
module mcb_bank import mcb_pkg::*; (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  wr_en_i,
  input  logic  over_en_i,
  input  word_t status_i,
  input  word_t addr_i,
  input  word_t misc_i,
  output word_t status_o,
  output word_t addr_o,
  output word_t misc_o
);
  word_t status_q, addr_q, misc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      status_q <= '0;
      addr_q   <= '0;
      misc_q   <= '0;
    end else if (wr_en_i) begin
      status_q <= status_i;
      addr_q   <= addr_i;
      misc_q   <= misc_i;
    end else if (over_en_i) begin
      status_q[ST_OVER] <= 1'b1;
    end
  end

  assign status_o = status_q;
  assign addr_o   = addr_q;
  assign misc_o   = misc_q;

  // R9
  write_sets_val_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> status_o[ST_VAL]);

  // R10
  over_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (over_en_i && !wr_en_i) |=> status_o[ST_OVER] && $stable(addr_o) && $stable(misc_o));

  // R3
  bank_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_en_i && !over_en_i) |=> $stable(status_o) && $stable(addr_o));
endmodule

// File: rtl/mc_bank_logger.sv
module mc_bank_logger import mcb_pkg::*; #(
  parameter  int NUM_BANKS = 4,
  localparam int IDX_W     = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [WORD_W-1:0]           cap_i,
  input  logic [WORD_W-1:0]           gctl_i,
  input  logic                        mce_en_i,
  input  logic [NUM_BANKS*WORD_W-1:0] bank_ctl_i,
  input  logic                        req_i,
  input  logic [CAP_CNT_W-1:0]        req_bank_i,
  input  logic [WORD_W-1:0]           req_status_i,
  input  logic [WORD_W-1:0]           req_gstatus_i,
  input  logic [WORD_W-1:0]           req_addr_i,
  input  logic [WORD_W-1:0]           req_misc_i,
  input  logic                        req_uncond_i,
  output logic                        irq_o,
  output logic                        reset_req_o,
  output logic                        reject_o,
  output logic [1:0]                  reject_code_o,
  input  logic [IDX_W-1:0]            obs_bank_i,
  output logic [WORD_W-1:0]           obs_status_o,
  output logic [WORD_W-1:0]           obs_addr_o,
  output logic [WORD_W-1:0]           obs_misc_o,
  output logic [WORD_W-1:0]           gstatus_o
);
  localparam word_t OVER_BIT = word_t'(1) << ST_OVER;

  word_t bank_st [NUM_BANKS];
  word_t bank_ad [NUM_BANKS];
  word_t bank_mi [NUM_BANKS];

  word_t gstat_q;
  word_t old_st, sel_ctl, log_st;
  logic [IDX_W-1:0] sel;
  rej_e  rej_code;
  act_e  act;
  logic  accept, do_write, do_over;
  logic  irq_q, rst_req_q, rej_q;
  logic [1:0] code_q;

  assign sel = req_bank_i[IDX_W-1:0];

  always_comb begin
    old_st  = '0;
    sel_ctl = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (sel == IDX_W'(b)) begin
        old_st  = bank_st[b];
        sel_ctl = bank_ctl_i[b*WORD_W +: WORD_W];
      end
    end
  end

  mcb_screen #(.NUM_BANKS(NUM_BANKS)) u_screen (
    .cap_i    (cap_i),
    .bank_i   (req_bank_i),
    .status_i (req_status_i),
    .code_o   (rej_code)
  );

  mcb_decide u_decide (
    .status_i     (req_status_i),
    .uncond_i     (req_uncond_i),
    .gstat_i      (gstat_q),
    .cap_i        (cap_i),
    .gctl_i       (gctl_i),
    .bank_ctl_i   (sel_ctl),
    .mce_en_i     (mce_en_i),
    .old_status_i (old_st),
    .act_o        (act)
  );

  assign accept   = req_i && (rej_code == REJ_NONE);
  assign do_write = accept && ((act == ACT_LOG_UC) || (act == ACT_LOG_CE));
  assign do_over  = accept && (act == ACT_MARK_OVER);
  // overflow when the slot already held a valid record
  assign log_st   = req_status_i | (old_st[ST_VAL] ? OVER_BIT : '0);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic hit;
    assign hit = (sel == IDX_W'(b));
    mcb_bank u_bank (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wr_en_i   (do_write && hit),
      .over_en_i (do_over && hit),
      .status_i  (log_st),
      .addr_i    (req_addr_i),
      .misc_i    (req_misc_i),
      .status_o  (bank_st[b]),
      .addr_o    (bank_ad[b]),
      .misc_o    (bank_mi[b])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gstat_q   <= '0;
      irq_q     <= 1'b0;
      rst_req_q <= 1'b0;
      rej_q     <= 1'b0;
      code_q    <= REJ_NONE;
    end else begin
      irq_q     <= accept && (act == ACT_LOG_UC);
      rst_req_q <= accept && (act == ACT_ESCALATE);
      rej_q     <= req_i && (rej_code != REJ_NONE);
      code_q    <= req_i ? rej_code : REJ_NONE;
      if (accept && (act == ACT_LOG_UC)) gstat_q <= req_gstatus_i;
    end
  end

  assign irq_o         = irq_q;
  assign reset_req_o   = rst_req_q;
  assign reject_o      = rej_q;
  assign reject_code_o = code_q;
  assign gstatus_o     = gstat_q;
  assign obs_status_o  = bank_st[obs_bank_i];
  assign obs_addr_o    = bank_ad[obs_bank_i];
  assign obs_misc_o    = bank_mi[obs_bank_i];

  // R7
  irq_loads_gstat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (gstatus_o == $past(req_gstatus_i)));

  // R2
  reject_keeps_gstat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reject_o |-> $stable(gstatus_o));

  // R6
  reset_keeps_gstat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reset_req_o |-> $stable(gstatus_o) && !irq_o);

  // R11
  pulse_follows_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reject_o || irq_o || reset_req_o) |-> $past(req_i));
endmodule

// File: tb/tb_mc_bank_logger.sv
module tb_mc_bank_logger;
  import mcb_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int NB = 4;
  localparam word_t VAL  = 64'h8000_0000_0000_0000;
  localparam word_t OVER = 64'h4000_0000_0000_0000;
  localparam word_t UC   = 64'h2000_0000_0000_0000;
  localparam word_t AR   = 64'h0080_0000_0000_0000;
  localparam word_t MCIP = 64'h4;

  typedef struct {
    logic irq, rst, rej;
    logic [1:0] code;
    logic [1:0] ob;
    word_t st, ad, mi, gs;
    string tag;
  } exp_t;

  logic clk_i = 0, rst_ni = 0;
  word_t cap_i, gctl_i;
  logic mce_en_i;
  logic [NB*WORD_W-1:0] bank_ctl_i;
  logic req_i = 0;
  logic [7:0] req_bank_i = '0;
  word_t req_status_i = '0, req_gstatus_i = '0, req_addr_i = '0, req_misc_i = '0;
  logic req_uncond_i = 0;
  logic irq_o, reset_req_o, reject_o;
  logic [1:0] reject_code_o;
  logic [1:0] obs_bank_i = '0;
  word_t obs_status_o, obs_addr_o, obs_misc_o, gstatus_o;

  int checks = 0, errors = 0;
  bit done = 0;
  exp_t q[$];

  word_t m_st [NB];
  word_t m_ad [NB];
  word_t m_mi [NB];
  word_t m_gs;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  mc_bank_logger #(.NUM_BANKS(NB)) dut (.*);

  function automatic word_t ctl_of(int b);
    return bank_ctl_i[b*WORD_W +: WORD_W];
  endfunction

  task automatic check(input string tag, input logic ok, input string act, input string exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%s expected=%s", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 0; req_i = 0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1;
    for (int b = 0; b < NB; b++) begin m_st[b] = '0; m_ad[b] = '0; m_mi[b] = '0; end
    m_gs = '0;
    for (int b = 0; b < NB; b++) begin
      obs_bank_i = 2'(b);
      #1;
      check("R1 bank clear", obs_status_o == '0 && obs_addr_o == '0 && obs_misc_o == '0,
            $sformatf("%h/%h/%h", obs_status_o, obs_addr_o, obs_misc_o), "0/0/0");
    end
    check("R1 outputs idle", {irq_o, reset_req_o, reject_o} == 3'b0 && gstatus_o == '0,
          $sformatf("%b %h", {irq_o, reset_req_o, reject_o}, gstatus_o), "000 0");
  endtask

  // reference model per requirements, then drive and queue expectation
  task automatic inject(input logic [7:0] bank, input word_t st, input word_t gs,
                        input word_t ad, input word_t mi, input logic unc, input string tag);
    exp_t e;
    logic [1:0] code;
    int b;
    word_t old;
    e.irq = 0; e.rst = 0; e.rej = 0; e.tag = tag;
    if (cap_i == '0) code = 2'd1;
    else if (bank >= cap_i[7:0] || bank >= 8'(NB)) code = 2'd2;
    else if (!st[63]) code = 2'd3;
    else code = 2'd0;
    e.code = code;
    b = (code == 0) ? int'(bank) : 0;
    if (code != 0) begin
      e.rej = 1;
    end else begin
      old = m_st[b];
      if (!unc && !st[55] && m_gs[2]) begin
      end else if (st[61]) begin
        if (cap_i[8] && gctl_i != '1) begin
        end else if (ctl_of(b) != '1) begin
        end else if (m_gs[2] || !mce_en_i) begin
          e.rst = 1;
        end else begin
          m_st[b] = st | (old[63] ? OVER : '0);
          m_ad[b] = ad; m_mi[b] = mi; m_gs = gs;
          e.irq = 1;
        end
      end else if (!old[63] || !old[61]) begin
        m_st[b] = st | (old[63] ? OVER : '0);
        m_ad[b] = ad; m_mi[b] = mi;
      end else begin
        m_st[b] = old | OVER;
      end
    end
    e.ob = 2'(b); e.st = m_st[b]; e.ad = m_ad[b]; e.mi = m_mi[b]; e.gs = m_gs;
    @(negedge clk_i);
    req_i = 1; req_bank_i = bank; req_status_i = st; req_gstatus_i = gs;
    req_addr_i = ad; req_misc_i = mi; req_uncond_i = unc;
    q.push_back(e);
  endtask

  task automatic idle();
    @(negedge clk_i);
    req_i = 0;
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk_i);
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        #(CLK_PERIOD/4);
        obs_bank_i = e.ob;
        #1;
        check(e.tag, {irq_o, reset_req_o, reject_o, reject_code_o} == {e.irq, e.rst, e.rej, e.code} &&
              obs_status_o == e.st && obs_addr_o == e.ad && obs_misc_o == e.mi && gstatus_o == e.gs,
              $sformatf("pulses=%b%b%b code=%0d st=%h ad=%h mi=%h gs=%h", irq_o, reset_req_o, reject_o,
                        reject_code_o, obs_status_o, obs_addr_o, obs_misc_o, gstatus_o),
              $sformatf("pulses=%b%b%b code=%0d st=%h ad=%h mi=%h gs=%h", e.irq, e.rst, e.rej,
                        e.code, e.st, e.ad, e.mi, e.gs));
      end else if (rst_ni && !done) begin
        #(CLK_PERIOD/4);
        check("R11 idle pulses low", {irq_o, reset_req_o, reject_o} == 3'b0,
              $sformatf("%b", {irq_o, reset_req_o, reject_o}), "000");
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      errors++;
      $display("FAIL R11 watchdog actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    cap_i = 64'h104; gctl_i = '1; mce_en_i = 1; bank_ctl_i = '1;
    do_reset();

    // R2 reject reasons and priority
    cap_i = '0;
    inject(8'd7, 64'h0, 64'h0, 64'h1, 64'h2, 0, "R2 no capability wins");
    idle();
    cap_i = 64'h104;
    inject(8'd5, VAL, 64'h0, 64'h1, 64'h2, 0, "R2 bank beyond storage");
    inject(8'd9, 64'h0, 64'h0, 64'h1, 64'h2, 0, "R2 bank before status");
    inject(8'd0, 64'h11, 64'h0, 64'h1, 64'h2, 0, "R2 status invalid");
    idle();
    cap_i = 64'h102;
    inject(8'd3, VAL, 64'h0, 64'h1, 64'h2, 0, "R2 bank beyond cap count");
    idle();
    cap_i = 64'h104;

    // R9 corrected into empty, then over valid corrected
    inject(8'd0, VAL | 64'h21, 64'h0, 64'hA0, 64'hB0, 0, "R9 corrected into empty");
    inject(8'd0, VAL | 64'h22, 64'h0, 64'hA1, 64'hB1, 0, "R9 corrected overwrite sets overflow");
    idle();

    // R7 uncorrected logged with interrupt, sets check in progress
    inject(8'd1, VAL | UC | 64'h33, MCIP | 64'h1, 64'hC0, 64'hD0, 0, "R7 uncorrected logged");
    idle();

    // R3 ignore while in progress, unless unconditional
    inject(8'd2, VAL | 64'h44, 64'h0, 64'hE0, 64'hF0, 0, "R3 ignored while in progress");
    inject(8'd2, VAL | 64'h45, 64'h0, 64'hE1, 64'hF1, 1, "R3 unconditional logs");
    idle();
    // R6 action required uncorrected escalates
    inject(8'd3, VAL | UC | AR, 64'h0, 64'h99, 64'h98, 0, "R6 escalate while in progress");
    idle();
    // R10 corrected meets pending uncorrected
    inject(8'd1, VAL | 64'h55, 64'h0, 64'h77, 64'h66, 1, "R10 only overflow marked");
    idle();

    do_reset();
    // R8 uncorrected over valid entry
    inject(8'd0, VAL | UC | 64'h1, 64'h0, 64'h10, 64'h20, 0, "R8 first uncorrected");
    inject(8'd0, VAL | UC | 64'h2, 64'h0, 64'h11, 64'h21, 0, "R8 second sets overflow");
    idle();
    // R4 global control suppression
    gctl_i = 64'hFFFF_FFFF_FFFF_FFFE;
    inject(8'd1, VAL | UC | 64'h3, 64'h0, 64'h12, 64'h22, 0, "R4 dropped by global control");
    idle();
    cap_i = 64'h004;
    inject(8'd1, VAL | UC | 64'h4, 64'h0, 64'h13, 64'h23, 0, "R4 global control ignored without flag");
    idle();
    cap_i = 64'h104; gctl_i = '1;

    do_reset();
    // R5 bank control suppression
    bank_ctl_i[2*WORD_W +: WORD_W] = 64'h0;
    inject(8'd2, VAL | UC | 64'h5, 64'h0, 64'h14, 64'h24, 0, "R5 dropped by bank control");
    inject(8'd2, VAL | 64'h6, 64'h0, 64'h15, 64'h25, 0, "R5 corrected unaffected");
    idle();
    bank_ctl_i = '1;
    // R6 delivery disabled
    mce_en_i = 0;
    inject(8'd3, VAL | UC | 64'h7, 64'h0, 64'h16, 64'h26, 0, "R6 escalate when disabled");
    idle();
    mce_en_i = 1;
    // R11 back to back
    inject(8'd3, VAL | UC | 64'h8, 64'h0, 64'h17, 64'h27, 0, "R11 back to back first");
    inject(8'd2, VAL | 64'h9, 64'h0, 64'h18, 64'h28, 0, "R11 back to back second");
    idle();
    repeat (3) @(negedge clk_i);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule